// File: doc/BRIEF.md
# Abstract Register Access Sequencer

This block sits in a debug unit between the debugger-facing register port and a halted hart. The debugger writes a 32-bit abstract command. The block decodes it and, if the command is legal, fills a short instruction buffer with RISC-V instruction words. Those words move one general, floating-point or control/status register to or from a fixed data-buffer address. The block then raises a go flag toward the selected hart and reports itself busy. The hart fetches and runs the buffer, which is outside this block, and signals completion on a single acknowledgement input. That input drops both busy and go.

A sticky three-bit error code records why a command was refused. While the code is non-zero, further commands are dropped without effect. The debugger clears the code by writing ones to a status location. The buffer can be read one word at a time through an index port. The program buffer is assumed to start at the address directly after the last buffer word, and post-execute jumps are built on that assumption.

Top module: `abs_cmd_sequencer`

## Requirements
- R1: After reset, busy is 0, the error code is 0, every go bit is 0 and every buffer word reads 0.
- R2: A command whose bits 31:24 are non-zero sets the error code to 2 (not supported) and leaves busy, go and the buffer unchanged.
- R3: While the error code is non-zero, a command write changes nothing: error, busy, go and the buffer keep their values.
- R4: A command written while busy, with the error code at 0, sets the error code to 1 (busy) and changes nothing else.
- R5: A command of type 0 aimed at a hart whose halted input is low sets the error code to 4 (halt/resume) and changes nothing else.
- R6: With transfer (bit 17) set, register numbers 0x1000 to 0x101F (bits 15:0) select integer register x(regno-0x1000). With write (bit 16) set, the first word is a load into that register from DATA_ADDR with base x0. With write clear, the first word is a store of that register to DATA_ADDR. Size code 2 (bits 22:20) gives the word form (funct3 010), and size code 3 gives the double form (funct3 011).
- R7: Register numbers 0x1020 to 0x103F select floating-point register f(regno-0x1020). These use the float load form (opcode 0000111) and the float store form (opcode 0100111), with the same size rule as R6.
- R8: With transfer set, a size code other than 2 or 3, or a register number of 0x1040 or above, sets the error code to 2 and changes nothing else.
- R9: A register number below 0x1000 is a CSR access of four words:
  - first, copy x8 into CSR 0x7B2;
  - second, move the data between x8 and DATA_ADDR (a load for a write), or read the CSR into x8 (for a read);
  - third, write x8 to the CSR (for a write), or store x8 to DATA_ADDR (for a read);
  - fourth, read CSR 0x7B2 back into x8.
- R10: The word after the generated ones depends on post-execute (bit 18). With bit 18 set, it is a jal x0 with byte offset 4*(ABS_WORDS-slot), landing just past the buffer. With bit 18 clear, it is EBREAK (0x00100073). All later slots are 0.
- R11: With transfer clear, the size and register number are not examined, and slot 0 holds only the final word of R10.
- R12: An accepted command raises busy and the go bit of the selected hart on the next clock edge, with no other go bit set, and rewrites the whole buffer.
- R13: The acknowledgement input clears busy and all go bits on the next edge while busy. It has no effect while idle.
- R14: A status write updates the error code to the old code AND NOT data bits 2:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 command, 1 status (error clear) |
| wr_data | input | 32 | Write data |
| hart_sel | input | HSEL_W | Hart addressed by a command |
| hart_halted | input | NHARTS | Per-hart halted state |
| halt_ack | input | 1 | Hart reports the buffer has finished |
| busy | output | 1 | Command in flight |
| cmd_err | output | 3 | Sticky error code |
| go | output | NHARTS | Per-hart go flag |
| buf_idx | input | IDX_W | Buffer word to read |
| buf_word | output | 32 | Buffer word at buf_idx (combinational) |

## Verification
Every registered result of this block is due one clock edge after the write or acknowledgement that causes it:
- busy, go, the error code and the buffer words all change at that edge;
- buf_word follows buf_idx within the same cycle.

A behavioural model in the bench steps on the same rising edge, using the input values driven half a cycle before. At each falling edge, its busy, error and go are compared with the outputs. After each command, the buffer is swept through the index port with a short settle delay, and each word is compared with words the model builds from queues of separately encoded instructions.

// File: rtl/abs_seq_pkg.sv
package abs_seq_pkg;

    typedef enum logic [2:0] {
        ERR_NONE   = 3'd0,
        ERR_BUSY   = 3'd1,
        ERR_NOTSUP = 3'd2,
        ERR_EXCEPT = 3'd3,
        ERR_HALT   = 3'd4
    } err_e;

    typedef enum logic [1:0] {
        XFER_NONE,
        XFER_GPR,
        XFER_FPR,
        XFER_CSR
    } xfer_e;

    typedef struct packed {
        logic [7:0]  kind;
        logic        rsv_hi;
        logic [2:0]  size;
        logic        rsv_lo;
        logic        postexec;
        logic        transfer;
        logic        write;
        logic [15:0] regno;
    } cmd_t;

    localparam logic [6:0]  OPC_LOAD   = 7'b0000011;
    localparam logic [6:0]  OPC_STORE  = 7'b0100011;
    localparam logic [6:0]  OPC_FLOAD  = 7'b0000111;
    localparam logic [6:0]  OPC_FSTORE = 7'b0100111;
    localparam logic [6:0]  OPC_SYSTEM = 7'b1110011;
    localparam logic [6:0]  OPC_JAL    = 7'b1101111;
    localparam logic [31:0] INSN_EBREAK = 32'h0010_0073;
    localparam logic [4:0]  GPR_SCRATCH = 5'd8;
    localparam logic [11:0] CSR_DBG_SCRATCH = 12'h7B2;

    function automatic logic [31:0] mk_itype(logic [6:0] opc, logic [2:0] f3,
                                             logic [4:0] rd, logic [4:0] rs1,
                                             logic [11:0] imm);
        return {imm, rs1, f3, rd, opc};
    endfunction

    function automatic logic [31:0] mk_stype(logic [6:0] opc, logic [2:0] f3,
                                             logic [4:0] rs2, logic [4:0] rs1,
                                             logic [11:0] imm);
        return {imm[11:5], rs2, rs1, f3, imm[4:0], opc};
    endfunction

    function automatic logic [31:0] mk_jal_x0(logic [20:0] ofs);
        return {ofs[20], ofs[10:1], ofs[11], ofs[19:12], 5'd0, OPC_JAL};
    endfunction

endpackage

// File: rtl/abs_cmd_decode.sv
module abs_cmd_decode
    import abs_seq_pkg::*;
(
    input  cmd_t  cmd,
    input  logic  target_halted,
    output err_e  dec_err,
    output xfer_e dec_xfer
);
    logic size_ok;

    always_comb begin
        size_ok  = (cmd.size == 3'd2) || (cmd.size == 3'd3);
        dec_err  = ERR_NONE;
        dec_xfer = XFER_NONE;
        if (cmd.kind != 8'd0) begin
            dec_err = ERR_NOTSUP;
        end else if (!target_halted) begin
            dec_err = ERR_HALT;
        end else if (cmd.transfer) begin
            if (cmd.regno < 16'h1000) begin
                dec_xfer = XFER_CSR;
            end else if (cmd.regno < 16'h1020) begin
                dec_xfer = XFER_GPR;
            end else if (cmd.regno < 16'h1040) begin
                dec_xfer = XFER_FPR;
            end else begin
                dec_err = ERR_NOTSUP;
            end
            if (dec_xfer != XFER_NONE && !size_ok) begin
                dec_err = ERR_NOTSUP;
            end
        end
    end
endmodule

// File: rtl/abs_insn_build.sv
module abs_insn_build
    import abs_seq_pkg::*;
#(
    parameter int          ABS_WORDS = 5,
    parameter logic [11:0] DATA_ADDR = 12'h380
) (
    input  xfer_e                         xfer,
    input  logic                          write,
    input  logic                          wide,
    input  logic [4:0]                    regidx,
    input  logic [11:0]                   csr,
    input  logic                          postexec,
    output logic [ABS_WORDS-1:0][31:0]    words
);
    localparam int BODY_MAX = 4;

    logic [31:0] body [BODY_MAX];
    logic [2:0]  nbody;
    logic [2:0]  f3m;
    logic [20:0] jofs;
    logic [31:0] tail;

    always_comb begin
        body  = '{default: '0};
        nbody = 3'd0;
        f3m   = wide ? 3'b011 : 3'b010;
        unique case (xfer)
            XFER_GPR: begin
                body[0] = write ? mk_itype(OPC_LOAD, f3m, regidx, 5'd0, DATA_ADDR)
                                : mk_stype(OPC_STORE, f3m, regidx, 5'd0, DATA_ADDR);
                nbody = 3'd1;
            end
            XFER_FPR: begin
                body[0] = write ? mk_itype(OPC_FLOAD, f3m, regidx, 5'd0, DATA_ADDR)
                                : mk_stype(OPC_FSTORE, f3m, regidx, 5'd0, DATA_ADDR);
                nbody = 3'd1;
            end
            XFER_CSR: begin
                body[0] = mk_itype(OPC_SYSTEM, 3'b001, 5'd0, GPR_SCRATCH, CSR_DBG_SCRATCH);
                body[1] = write ? mk_itype(OPC_LOAD, f3m, GPR_SCRATCH, 5'd0, DATA_ADDR)
                                : mk_itype(OPC_SYSTEM, 3'b010, GPR_SCRATCH, 5'd0, csr);
                body[2] = write ? mk_itype(OPC_SYSTEM, 3'b001, 5'd0, GPR_SCRATCH, csr)
                                : mk_stype(OPC_STORE, f3m, GPR_SCRATCH, 5'd0, DATA_ADDR);
                body[3] = mk_itype(OPC_SYSTEM, 3'b010, GPR_SCRATCH, 5'd0, CSR_DBG_SCRATCH);
                nbody = 3'd4;
            end
            default: nbody = 3'd0;
        endcase
        jofs = 21'(4 * ABS_WORDS) - {16'd0, nbody, 2'b00};
        tail = postexec ? mk_jal_x0(jofs) : INSN_EBREAK;
    end

    for (genvar k = 0; k < ABS_WORDS; k++) begin : g_slot
        if (k < BODY_MAX) begin : g_body
            assign words[k] = (k < int'(nbody))  ? body[k] :
                              (k == int'(nbody)) ? tail : 32'd0;
        end else begin : g_tail
            assign words[k] = (k == int'(nbody)) ? tail : 32'd0;
        end
    end
endmodule

// File: rtl/abs_cmd_sequencer.sv
module abs_cmd_sequencer
    import abs_seq_pkg::*;
#(
    parameter int          NHARTS    = 4,
    parameter int          ABS_WORDS = 5,
    parameter logic [11:0] DATA_ADDR = 12'h380,
    localparam int         HSEL_W    = (NHARTS > 1) ? $clog2(NHARTS) : 1,
    localparam int         IDX_W     = $clog2(ABS_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [31:0]       wr_data,
    input  logic [HSEL_W-1:0] hart_sel,
    input  logic [NHARTS-1:0] hart_halted,
    input  logic              halt_ack,
    output logic              busy,
    output logic [2:0]        cmd_err,
    output logic [NHARTS-1:0] go,
    input  logic [IDX_W-1:0]  buf_idx,
    output logic [31:0]       buf_word
);
    typedef struct packed {
        logic                         busy;
        err_e                         err;
        logic [NHARTS-1:0]            go;
        logic [ABS_WORDS-1:0][31:0]   ibuf;
    } state_t;

    state_t state_d, state_q;

    cmd_t                       cmd;
    err_e                       dec_err;
    xfer_e                      dec_xfer;
    logic [NHARTS-1:0]          sel_vec;
    logic                       target_halted;
    logic [ABS_WORDS-1:0][31:0] new_words;
    logic                       cmd_wr, stat_wr;
    logic                       unused_rsv;

    assign cmd        = cmd_t'(wr_data);
    assign unused_rsv = cmd.rsv_hi ^ cmd.rsv_lo;

    for (genvar h = 0; h < NHARTS; h++) begin : g_sel
        assign sel_vec[h] = (hart_sel == HSEL_W'(h));
    end
    assign target_halted = |(sel_vec & hart_halted);

    abs_cmd_decode u_decode (
        .cmd           (cmd),
        .target_halted (target_halted),
        .dec_err       (dec_err),
        .dec_xfer      (dec_xfer)
    );

    abs_insn_build #(
        .ABS_WORDS (ABS_WORDS),
        .DATA_ADDR (DATA_ADDR)
    ) u_build (
        .xfer     (dec_xfer),
        .write    (cmd.write),
        .wide     (cmd.size == 3'd3),
        .regidx   (cmd.regno[4:0]),
        .csr      (cmd.regno[11:0]),
        .postexec (cmd.postexec),
        .words    (new_words)
    );

    always_comb begin
        state_d = state_q;
        cmd_wr  = wr_en && !wr_sel;
        stat_wr = wr_en && wr_sel;
        if (halt_ack && state_q.busy) begin
            state_d.busy = 1'b0;
            state_d.go   = '0;
        end
        if (stat_wr) begin
            state_d.err = err_e'(state_q.err & ~wr_data[2:0]);
        end else if (cmd_wr && state_q.err == ERR_NONE) begin
            if (state_q.busy) begin
                state_d.err = ERR_BUSY;
            end else if (dec_err != ERR_NONE) begin
                state_d.err = dec_err;
            end else begin
                state_d.ibuf = new_words;
                state_d.busy = 1'b1;
                state_d.go   = sel_vec;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign busy     = state_q.busy;
    assign cmd_err  = state_q.err;
    assign go       = state_q.go;
    assign buf_word = (int'(buf_idx) < ABS_WORDS) ? state_q.ibuf[buf_idx] : 32'd0;
endmodule

// File: rtl/abs_cmd_sequencer_chk.sv
module abs_cmd_sequencer_chk #(
    parameter int NHARTS = 4,
    parameter int HSEL_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              wr_sel,
    input logic [31:0]       wr_data,
    input logic              halt_ack,
    input logic              busy,
    input logic [2:0]        cmd_err,
    input logic [NHARTS-1:0] go
);
    assert_go_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(go));

    assert_go_with_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($countones(go) == 1));

    assert_ack_clears_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && halt_ack) |=> (!busy && go == '0));

    assert_busy_error_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel && busy && cmd_err == 3'd0) |=> (cmd_err == 3'd1));

    assert_sticky_ignore_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel && cmd_err != 3'd0 && !halt_ack)
        |=> (cmd_err == $past(cmd_err) && busy == $past(busy) && go == $past(go)));

    assert_w1c_R14: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel) |=> (cmd_err == ($past(cmd_err) & ~$past(wr_data[2:0]))));

    assert_bad_type_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel && !busy && cmd_err == 3'd0 && wr_data[31:24] != 8'd0)
        |=> (cmd_err == 3'd2 && !busy));
endmodule

bind abs_cmd_sequencer abs_cmd_sequencer_chk #(
    .NHARTS (NHARTS),
    .HSEL_W (HSEL_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .halt_ack (halt_ack),
    .busy     (busy),
    .cmd_err  (cmd_err),
    .go       (go)
);

// File: tb/abs_cmd_sequencer_test.sv
`timescale 1ns/1ps
module abs_cmd_sequencer_test;
    localparam int NH = 4;
    localparam int AW = 5;
    localparam int DADDR = 'h380;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic [1:0]  hart_sel = '0;
    logic [3:0]  hart_halted = 4'b1011;
    logic        halt_ack = 1'b0;
    logic        busy;
    logic [2:0]  cmd_err;
    logic [3:0]  go;
    logic [2:0]  buf_idx = '0;
    logic [31:0] buf_word;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    string req = "R1";

    always #2.5 clk = ~clk;

    abs_cmd_sequencer uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .hart_sel(hart_sel), .hart_halted(hart_halted), .halt_ack(halt_ack),
        .busy(busy), .cmd_err(cmd_err), .go(go), .buf_idx(buf_idx), .buf_word(buf_word)
    );

    // reference model state
    bit          m_busy;
    logic [2:0]  m_err;
    logic [3:0]  m_go;
    logic [31:0] m_buf [AW];
    logic [31:0] wq [$];

    function automatic logic [31:0] e_i(int op, int f3, int rd, int rs1, int imm);
        logic [31:0] v;
        v = 32'(imm) * 32'h0010_0000 + 32'(rs1) * 32'h8000 + 32'(f3) * 32'h1000 + 32'(rd) * 128 + 32'(op);
        return v;
    endfunction

    function automatic logic [31:0] e_s(int op, int f3, int rs2, int rs1, int imm);
        logic [31:0] v;
        v = 32'(imm / 32) * 32'h0200_0000 + 32'(rs2) * 32'h0010_0000 + 32'(rs1) * 32'h8000
          + 32'(f3) * 32'h1000 + 32'(imm % 32) * 128 + 32'(op);
        return v;
    endfunction

    function automatic logic [31:0] e_jal(int off);
        logic [31:0] v;
        v = 32'((off / 2) % 1024) * 32'h0020_0000 + 32'((off / 2048) % 2) * 32'h0010_0000
          + 32'((off / 4096) % 256) * 32'h1000 + 32'h6F;
        return v;
    endfunction

    function automatic logic [31:0] mkcmd(int kind, int sz, bit post, bit xf, bit wr, int rn);
        return {8'(kind), 1'b0, 3'(sz), 1'b0, post, xf, wr, 16'(rn)};
    endfunction

    task automatic model_cmd(input logic [31:0] c, input bit hl, output int e);
        int kind, sz, rn, f3;
        bit post, xf, wr;
        kind = int'(c[31:24]); sz = int'(c[22:20]); post = c[18]; xf = c[17];
        wr = c[16]; rn = int'(c[15:0]);
        wq.delete();
        e = 0;
        if (kind != 0) e = 2;
        else if (!hl) e = 4;
        else if (xf) begin
            if (rn >= 'h1040) e = 2;
            else if (sz != 2 && sz != 3) e = 2;
            else begin
                f3 = sz;
                if (rn >= 'h1020)
                    wq.push_back(wr ? e_i('h07, f3, rn - 'h1020, 0, DADDR) : e_s('h27, f3, rn - 'h1020, 0, DADDR));
                else if (rn >= 'h1000)
                    wq.push_back(wr ? e_i('h03, f3, rn - 'h1000, 0, DADDR) : e_s('h23, f3, rn - 'h1000, 0, DADDR));
                else begin
                    wq.push_back(e_i('h73, 1, 0, 8, 'h7B2));
                    wq.push_back(wr ? e_i('h03, f3, 8, 0, DADDR) : e_i('h73, 2, 8, 0, rn));
                    wq.push_back(wr ? e_i('h73, 1, 0, 8, rn) : e_s('h23, f3, 8, 0, DADDR));
                    wq.push_back(e_i('h73, 2, 8, 0, 'h7B2));
                end
            end
        end
        if (e == 0) begin
            wq.push_back(post ? e_jal(4 * (AW - wq.size())) : 32'h0010_0073);
            while (wq.size() < AW) wq.push_back(32'd0);
        end
    endtask

    always @(posedge clk) begin
        bit ob;
        logic [2:0] oe;
        int e;
        if (!rst_n) begin
            m_busy = 0; m_err = 0; m_go = 0;
            for (int k = 0; k < AW; k++) m_buf[k] = 0;
        end else begin
            ob = m_busy; oe = m_err;
            if (halt_ack && ob) begin m_busy = 0; m_go = 0; end
            if (wr_en && wr_sel) m_err = oe & ~wr_data[2:0];
            else if (wr_en && oe == 0) begin
                if (ob) m_err = 1;
                else begin
                    model_cmd(wr_data, hart_halted[hart_sel], e);
                    if (e != 0) m_err = 3'(e);
                    else begin
                        for (int k = 0; k < AW; k++) m_buf[k] = wq[k];
                        m_busy = 1;
                        m_go = 4'b0001 << hart_sel;
                    end
                end
            end
        end
    end

    task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // per-cycle comparison (busy/go: R12, R13; error code: current requirement)
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check(busy == m_busy, "busy (R12/R13 timing)", 32'(busy), 32'(m_busy));
            check(go == m_go, "go (R12/R13 timing)", 32'(go), 32'(m_go));
            check(cmd_err == m_err, "error code", 32'(cmd_err), 32'(m_err));
        end
    end

    task automatic chk_buf();
        for (int k = 0; k < AW; k++) begin
            buf_idx = 3'(k);
            #0.5;
            check(buf_word == m_buf[k], $sformatf("buffer slot %0d", k), buf_word, m_buf[k]);
        end
    endtask

    task automatic wr(input bit sel, input logic [31:0] d, input int h);
        @(negedge clk);
        wr_en = 1; wr_sel = sel; wr_data = d; hart_sel = 2'(h);
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic ack();
        @(negedge clk); halt_ack = 1;
        @(negedge clk); halt_ack = 0;
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        req = "R1";
        check(busy == 0, "reset busy", 32'(busy), 0);
        check(cmd_err == 0, "reset error", 32'(cmd_err), 0);
        check(go == 0, "reset go", 32'(go), 0);
        for (int k = 0; k < AW; k++) begin
            buf_idx = 3'(k); #0.5;
            check(buf_word == 0, "reset buffer", buf_word, 0);
        end
        rst_n = 1;

        req = "R6";  wr(0, mkcmd(0, 2, 0, 1, 0, 'h1005), 0); chk_buf();
        req = "R4";  wr(0, mkcmd(0, 3, 0, 1, 1, 'h1001), 0); chk_buf();
        req = "R3";  wr(0, mkcmd(0, 2, 0, 1, 1, 'h1002), 0); chk_buf();
        req = "R14"; wr(1, 32'h2, 0); wr(1, 32'h1, 0);
        req = "R13"; ack(); ack();
        req = "R2";  wr(0, mkcmd(1, 2, 0, 1, 0, 'h1005), 0); chk_buf();
        req = "R3";  wr(0, mkcmd(0, 2, 0, 1, 0, 'h1006), 0); chk_buf();
        req = "R14"; wr(1, 32'h7, 0);
        req = "R5";  wr(0, mkcmd(0, 2, 0, 1, 0, 'h1005), 2); chk_buf(); wr(1, 32'h4, 0);
        req = "R7";  wr(0, mkcmd(0, 3, 1, 1, 1, 'h103F), 1); chk_buf(); ack();
        req = "R7";  wr(0, mkcmd(0, 2, 0, 1, 0, 'h1020), 3); chk_buf(); ack();
        req = "R9";  wr(0, mkcmd(0, 2, 0, 1, 0, 'h300), 3); chk_buf(); ack();
        req = "R10"; wr(0, mkcmd(0, 3, 1, 1, 1, 'h7C0), 0); chk_buf(); ack();
        req = "R8";  wr(0, mkcmd(0, 1, 0, 1, 0, 'h1003), 0); chk_buf(); wr(1, 32'h7, 0);
        req = "R8";  wr(0, mkcmd(0, 2, 0, 1, 0, 'h2000), 0); chk_buf(); wr(1, 32'h7, 0);
        req = "R11"; wr(0, mkcmd(0, 7, 1, 0, 0, 'hFFFF), 1); chk_buf(); ack();
        req = "R11"; wr(0, mkcmd(0, 0, 0, 0, 1, 'h0), 0); chk_buf(); ack();
        req = "R6";  wr(0, mkcmd(0, 3, 1, 1, 1, 'h101F), 3); chk_buf(); ack();
        req = "R12"; wr(0, mkcmd(0, 2, 0, 1, 1, 'h1010), 1);
        @(negedge clk);
        check(go == 4'b0010, "go after accept", 32'(go), 32'h2);
        ack();
        repeat (2) @(negedge clk);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule